// File: doc/BRIEF.md
# Lane-Unfolded Ninth-Order-Lag Recursive Filter

This block evaluates the first-order recursion y(n) = a·y(n−9) + x(n) on a stream of signed samples. It runs at a block rate rather than the sample rate: each accepted clock carries a vector of `LANES` consecutive samples and yields a vector of `LANES` outputs. The clock period can therefore be `LANES` times the sample period. The nine-sample feedback lag is split across the lanes. Each lane's result feeds a small delay line, and that line feeds the lane that needs the value. The destination lane is (s + 9) mod `LANES` for source lane s. The line depth, counted in blocks, is floor((s + 9) / `LANES`).

The supported widths are `LANES` = 2 and `LANES` = 3. With two lanes, lane 0 draws on lane 1 from five blocks earlier, and lane 1 draws on lane 0 from four blocks earlier. With three lanes, every lane draws on itself from three blocks earlier. In every case the delay lines together hold exactly nine registers.

The coefficient is a signed fraction with 15 fractional bits. Only clocks with the input valid flag set advance the recursion.

Top module: `unfolded_iir`

## Requirements
- R1: Lane i of `in_data` (bits [16i+15:16i]) holds sample n = LANES·k + i of block k, so lane 0 carries the earliest sample. Lane i of `out_data` holds y at that same index.
- R2: Each output is y(n) = P(n) + x(n), where P(n) is the scaled product of `coef` and y(n−9). The sum wraps modulo 2^16.
- R3: The scaled product takes the signed 32-bit product of `coef` and y(n−9), shifts it arithmetically right by 15 (rounding toward minus infinity) and keeps the low 16 bits.
- R4: The feedback routing follows the lane count. With LANES=2, lane 0 uses lane 1 from five valid blocks back, and lane 1 uses lane 0 from four valid blocks back. With LANES=3, each lane uses its own output from three valid blocks back.
- R5: A clock with `in_valid` low leaves the recursion state unchanged. Block lags are counted in valid blocks only.
- R6: `out_valid` equals `in_valid` from one clock earlier. `out_data` shows the result of the block accepted on that earlier clock.
- R7: After a clock with `in_valid` low, `out_data` keeps its previous value.
- R8: Reset drives `out_valid` and `out_data` to zero and clears every delay register. The first floor(9/LANES) valid blocks after reset therefore output their inputs unchanged.
- R9: With `coef` equal to zero, every output equals its input sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block present this clock |
| in_data | input | LANES*DW | Input samples, lane 0 in the low bits |
| coef | input | DW | Signed feedback coefficient with 15 fractional bits |
| out_valid | output | 1 | Output block present |
| out_data | output | LANES*DW | Output samples, lane 0 in the low bits |

## Verification
Every result of a block accepted on a clock edge is due one edge later. Both `out_valid` and `out_data` are registered exactly once after the combinational multiply-add, and the feedback taps are read in the same clock in which the block is accepted. The bench drives inputs and samples outputs on the falling edge. At each falling edge it compares the outputs with the expected values from the block it drove half a cycle before the last rising edge. A sample-indexed history model predicts those values. Idle clocks predict an unchanged `out_data`. Directed impulse checks fix the exact valid block in which the feedback first appears for each lane count: block 4 for two lanes and block 3 for three lanes.

// File: rtl/unf_iir_pkg.sv
package unf_iir_pkg;

    // Lane whose past output feeds lane 'lane' across a lag of 'lag' samples.
    function automatic int src_lane(input int lane, input int lanes, input int lag);
        return (lane + lanes * lag - lag) % lanes;
    endfunction

    // Lane that receives the output of lane 'src' after 'lag' samples.
    function automatic int dst_lane(input int src, input int lanes, input int lag);
        return (src + lag) % lanes;
    endfunction

    // Number of block registers on the edge leaving lane 'src'.
    function automatic int edge_depth(input int src, input int lanes, input int lag);
        return (src + lag) / lanes;
    endfunction

endpackage

// File: rtl/unf_mac.sv
module unf_mac #(
    parameter int DW   = 16,
    parameter int FRAC = 15
) (
    input  logic [DW-1:0] fb,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] coef,
    output logic [DW-1:0] y
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;

    always_comb begin
        prod = PW'($signed(coef)) * PW'($signed(fb));
        y    = DW'(prod >>> FRAC) + x;
    end
endmodule

// File: rtl/unf_delay.sv
module unf_delay #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] stage;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (adv) begin
            line_d.stage[0] = din;
            for (int k = 1; k < DEPTH; k++) begin
                line_d.stage[k] = line_q.stage[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign dout = line_q.stage[DEPTH-1];
endmodule

// File: rtl/unfolded_iir.sv
module unfolded_iir
    import unf_iir_pkg::*;
#(
    parameter int LANES      = 2,
    parameter int DW         = 16,
    parameter int FRAC       = 15,
    parameter int LOOP_DELAY = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [LANES*DW-1:0] in_data,
    input  logic [DW-1:0]       coef,
    output logic                out_valid,
    output logic [LANES*DW-1:0] out_data
);
    localparam int BUS_W = LANES * DW;

    if (LANES < 1 || LANES > LOOP_DELAY) begin : g_bad_lanes
        $error("unfolded_iir: LANES must lie in 1..LOOP_DELAY");
    end

    logic [DW-1:0] tap    [LANES];
    logic [DW-1:0] y_lane [LANES];

    // One multiply-add per lane, fed by the edge that ends on it.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int SRC = src_lane(i, LANES, LOOP_DELAY);
        unf_mac #(.DW(DW), .FRAC(FRAC)) u_mac (
            .fb   (tap[SRC]),
            .x    (in_data[i*DW +: DW]),
            .coef (coef),
            .y    (y_lane[i])
        );
    end

    // One delay line per source lane, depth from the unfolding rule.
    for (genvar s = 0; s < LANES; s++) begin : g_edge
        localparam int DEPTH = edge_depth(s, LANES, LOOP_DELAY);
        unf_delay #(.DW(DW), .DEPTH(DEPTH)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (in_valid),
            .din   (y_lane[s]),
            .dout  (tap[s])
        );
    end

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] data;
    } out_t;

    out_t o_d, o_q;
    logic [BUS_W-1:0] y_bus;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            y_bus[i*DW +: DW] = y_lane[i];
        end
        o_d       = o_q;
        o_d.valid = in_valid;
        if (in_valid) begin
            o_d.data = y_bus;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_data  = o_q.data;
endmodule

// File: rtl/unfolded_iir_chk.sv
module unfolded_iir_chk #(
    parameter int LANES      = 2,
    parameter int DW         = 16,
    parameter int LOOP_DELAY = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [LANES*DW-1:0] in_data,
    input logic [DW-1:0]       coef,
    input logic                out_valid,
    input logic [LANES*DW-1:0] out_data
);
    localparam int MIN_DEPTH = LOOP_DELAY / LANES;

    logic [7:0] blk_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt <= '0;
        end else if (in_valid && blk_cnt != 8'hFF) begin
            blk_cnt <= blk_cnt + 8'd1;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6
    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)); // R7
    AST_ZERO_COEF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && coef == '0) |=> out_data == $past(in_data)); // R9
    AST_FILL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(blk_cnt) < MIN_DEPTH) |=> out_data == $past(in_data)); // R8
endmodule

bind unfolded_iir unfolded_iir_chk #(
    .LANES(LANES), .DW(DW), .LOOP_DELAY(LOOP_DELAY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef(coef), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/unfolded_iir_tb.sv
module unfolded_iir_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [15:0] coef = '0;
    logic [31:0] din2 = '0;
    logic [47:0] din3 = '0;
    logic        ov2, ov3;
    logic [31:0] dout2;
    logic [47:0] dout3;

    unfolded_iir #(.LANES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(din2), .coef(coef),
        .out_valid(ov2), .out_data(dout2));
    unfolded_iir #(.LANES(3)) u_dut3 (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(din3), .coef(coef),
        .out_valid(ov3), .out_data(dout3));

    int n_run = 0;
    int n_fail = 0;
    int hist2[$];
    int hist3[$];
    logic        exp_v = 1'b0;
    logic [47:0] exp2 = '0;
    logic [47:0] exp3 = '0;
    bit          done = 1'b0;

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_y(input int fb, input int x, input int a);
        int prod;
        int sum;
        prod = a * fb;
        sum  = (prod >>> 15) + x;
        return sum[15:0];
    endfunction

    task automatic model(input int lanes, ref int hist[$], input logic [47:0] x,
                         input logic [15:0] a, output logic [47:0] y);
        y = '0;
        for (int i = 0; i < lanes; i++) begin
            int n, fb, xi, a_i, v;
            logic [15:0] yi;
            n   = hist.size();
            fb  = (n >= 9) ? hist[n-9] : 0;
            xi  = $signed(x[16*i +: 16]);
            a_i = $signed(a);
            yi  = ref_y(fb, xi, a_i);
            y[16*i +: 16] = yi;
            v = $signed(yi);
            hist.push_back(v);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic tick(input logic v, input logic [31:0] x2, input logic [47:0] x3,
                        input logic [15:0] a);
        check("R6 out_valid lanes=2", {47'b0, ov2}, {47'b0, exp_v});
        check("R6 out_valid lanes=3", {47'b0, ov3}, {47'b0, exp_v});
        check(exp_v ? "R2 R3 data lanes=2" : "R7 hold lanes=2", {16'b0, dout2}, exp2);
        check(exp_v ? "R2 R3 data lanes=3" : "R7 hold lanes=3", dout3, exp3);
        vld  = v;
        din2 = x2;
        din3 = x3;
        coef = a;
        exp_v = v;
        if (v) begin
            logic [47:0] y2, y3;
            model(2, hist2, {16'b0, x2}, a, y2);
            model(3, hist3, x3, a, y3);
            exp2 = y2;
            exp3 = y3;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        vld   = 1'b0;
        din2  = '0;
        din3  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        hist2.delete();
        hist3.delete();
        exp_v = 1'b0;
        exp2  = '0;
        exp3  = '0;
        check("R8 reset valid lanes=2", {47'b0, ov2}, 48'd0);
        check("R8 reset valid lanes=3", {47'b0, ov3}, 48'd0);
        check("R8 reset data lanes=2", {16'b0, dout2}, 48'd0);
        check("R8 reset data lanes=3", dout3, 48'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 R4 R5: impulse in lane 0, idle clocks between blocks.
        for (int b = 0; b < 6; b++) begin
            logic [15:0] s;
            s = (b == 0) ? 16'd1000 : 16'd0;
            tick(1'b1, {16'd0, s}, {32'd0, s}, 16'h4000);
            if (b == 3) check("R4 R1 lanes=3 lane0 at block 3", dout3, {32'd0, 16'd500});
            if (b == 4) check("R4 R1 lanes=2 lane1 at block 4", {16'b0, dout2}, {16'd0, 16'd500, 16'd0});
            if (b == 1 || b == 2) tick(1'b0, '0, '0, 16'h4000);
        end
        tick(1'b0, '0, '0, 16'h4000);

        // R3: floor rounding of a negative product.
        do_reset();
        for (int b = 0; b < 5; b++) begin
            logic [15:0] s;
            s = (b == 0) ? 16'hFFFD : 16'd0;
            tick(1'b1, {16'd0, s}, {32'd0, s}, 16'h4000);
            if (b == 3) check("R3 floor lanes=3", dout3, {32'd0, 16'hFFFE});
            if (b == 4) check("R3 floor lanes=2", {16'b0, dout2}, {16'd0, 16'hFFFE, 16'd0});
        end

        // R8 fill pass-through, then long mixed traffic (R2 R5 R6 R7).
        do_reset();
        begin
            int blk;
            blk = 0;
            for (int c = 0; c < 400; c++) begin
                logic v;
                logic [31:0] r2;
                logic [47:0] r3;
                v  = ($urandom % 4) != 0;
                r2 = $urandom;
                r3 = {16'($urandom), 32'($urandom)};
                tick(v, r2, r3, 16'hA5C3);
                if (v) begin
                    if (blk < 4) check("R8 fill pass lanes=2", {16'b0, dout2}, {16'b0, r2});
                    if (blk < 3) check("R8 fill pass lanes=3", dout3, r3);
                    blk++;
                end
            end
        end

        // R9: zero coefficient.
        for (int c = 0; c < 20; c++) begin
            logic [31:0] r2;
            logic [47:0] r3;
            r2 = $urandom;
            r3 = {16'($urandom), 32'($urandom)};
            tick(1'b1, r2, r3, 16'h0000);
            check("R9 zero coef lanes=2", {16'b0, dout2}, {16'b0, r2});
            check("R9 zero coef lanes=3", dout3, r3);
        end

        // Full-scale coefficient near wrap.
        for (int c = 0; c < 60; c++) begin
            tick(1'b1, {16'h7FFF, 16'h8000}, {16'h7FFF, 16'h8001, 16'h7FFE}, 16'h7FFF);
        end
        tick(1'b0, '0, '0, 16'h7FFF);
        tick(1'b0, '0, '0, 16'h7FFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule